// File: doc/BRIEF.md
# Two-Level Clustered Control Router Fabric

This block is the digital control-packet network that joins a host processor to sixteen compute tiles. The tiles form four groups of four. Each group has one group router, and one central router sits above the groups. A group router has eight ports: four face its local tiles, three are direct links to the other group routers, and one goes up to the central router. The central router has a port to each group router and one port to the host.

Every packet carries a 5-bit destination in its top bits, followed by a payload whose width is a parameter. Destination 0x10 names the host. Destinations 0x00 to 0x0F name tile number `dest[3:0]`, where `dest[3:2]` selects the group and `dest[1:0]` selects the tile within it. Traffic between tiles of the same group stays in the group router. Traffic to another group takes the direct peer link and does not pass through the central router. Traffic for the host goes up through the central router. Traffic from the host goes down through the central router and then through the group router. Every port uses a valid/ready handshake. Each router output is a single register stage, and where several inputs compete for one output, a round-robin arbiter chooses between them.

Top module: `cmesh_fabric`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every output valid is low and `err_flag` is low.
- R2: A packet from a tile to another tile of the same group appears on the destination tile output in the cycle after its input handshake, with the whole packet unchanged.
- R3: A packet from a tile to a tile of a different group appears at the destination two cycles after its input handshake. This is one hop in each group router, with no pass through the central router.
- R4: A packet from a tile addressed to 0x10 appears on the host output two cycles after its input handshake.
- R5: A packet from the host addressed to a tile 0x00–0x0F appears on that tile output two cycles after its input handshake.
- R6: A transfer happens only in a cycle where both valid and ready are high. An output whose ready is low keeps valid high and its packet unchanged. No packet is lost or delivered twice.
- R7: When two inputs keep requesting the same output, the grants alternate between them on successive transfers.
- R8: An illegal destination is accepted (ready high) and then dropped, so it reaches no output, and `err_flag` goes high and stays high until reset. For tile inputs the illegal codes are 0x11–0x1F. For the host input the illegal codes are 0x10–0x1F.
- R9: A packet on tile output k always carries destination k, and a packet on the host output always carries destination 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tile_in_valid | input | 16 | Per-tile packet valid toward the fabric |
| tile_in_ready | output | 16 | Per-tile ready from the fabric |
| tile_in_data | input | 16*(5+DATA_W) | Per-tile packets, tile k at slice k |
| tile_out_valid | output | 16 | Per-tile packet valid toward the tile |
| tile_out_ready | input | 16 | Per-tile ready from the tile |
| tile_out_data | output | 16*(5+DATA_W) | Per-tile delivered packets |
| host_in_valid | input | 1 | Host packet valid |
| host_in_ready | output | 1 | Ready toward the host |
| host_in_data | input | 5+DATA_W | Host packet |
| host_out_valid | output | 1 | Packet valid toward the host |
| host_out_ready | input | 1 | Host ready |
| host_out_data | output | 5+DATA_W | Packet toward the host |
| err_flag | output | 1 | Sticky illegal-address flag |

## Verification
A fault in a route decoder puts a packet on the wrong output, and the destination check shows this within one or two cycles of the handshake. A broken peer path changes the delivery latency from two cycles to some other value. A corrupt round-robin pointer shows up as two grants in a row to the same input once contention starts. A faulty output register either loses or duplicates a packet under back-pressure, and the scoreboard catches this because each payload carries a unique tag that must be delivered exactly once. A fault in the error logic leaves `err_flag` low after an illegal drop, or lets a dropped packet leak to an output, and both are seen within a few cycles.

// File: rtl/cmesh_pkg.sv
// Package: shared constants and address helpers for the clustered control fabric.
// Assumes 5-bit destinations: 0x10 is the host, 0x00-0x0F are tiles {group,tile}.
package cmesh_pkg;
    localparam int ADDR_W          = 5;
    localparam int NUM_GROUPS      = 4;
    localparam int TILES_PER_GROUP = 4;
    localparam int NUM_TILES       = NUM_GROUPS * TILES_PER_GROUP;
    localparam int PEER_CNT        = NUM_GROUPS - 1;
    localparam int GRP_PORTS       = TILES_PER_GROUP + PEER_CNT + 1;
    localparam int PORT_PEER0      = TILES_PER_GROUP;
    localparam int PORT_UP         = GRP_PORTS - 1;
    localparam int CTR_PORTS       = NUM_GROUPS + 1;
    localparam int PORT_HOST       = NUM_GROUPS;
    localparam logic [ADDR_W-1:0] HOST_ADDR = 5'h10;

    // True when the address names the host
    function automatic logic addr_is_host(input logic [ADDR_W-1:0] a);
        return a == HOST_ADDR;
    endfunction

    // True when the address names a tile
    function automatic logic addr_is_tile(input logic [ADDR_W-1:0] a);
        return !a[4];
    endfunction

    // Group number of a tile address
    function automatic logic [1:0] addr_group(input logic [ADDR_W-1:0] a);
        return a[3:2];
    endfunction

    // Tile number inside its group
    function automatic logic [1:0] addr_tile(input logic [ADDR_W-1:0] a);
        return a[1:0];
    endfunction

    // Peer slot k of group own links to group (own+1+k) mod 4
    function automatic logic [1:0] peer_slot(input logic [1:0] own, input logic [1:0] dst);
        return dst - own - 2'd1;
    endfunction
endpackage

// File: rtl/cmesh_rr_arbiter.sv
// Round-robin arbiter: grants the first requester at or after the pointer.
// Assumes N >= 2. The pointer moves past the winner only when advance is high.
module cmesh_rr_arbiter #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         advance,
    output logic [N-1:0] grant
);
    localparam int PW = $clog2(N);

    logic [PW-1:0] ptr;
    logic [PW-1:0] nxt;

    // Search requesters starting from the pointer position
    always_comb begin
        int  win;
        logic found;
        grant = '0;
        found = 1'b0;
        win   = 0;
        for (int off = 0; off < N; off++) begin
            int idx;
            idx = (int'(ptr) + off) % N;
            if (!found && req[idx]) begin
                grant[idx] = 1'b1;
                found      = 1'b1;
                win        = idx;
            end
        end
        nxt = PW'((win + 1) % N);
    end

    // Move the pointer past the winner on an accepted grant
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr <= '0;
        else if (advance)  ptr <= nxt;
    end
endmodule

// File: rtl/cmesh_out_port.sv
// Output port: arbitrates N requesters into one registered valid/ready stage.
// Assumes each requester's data is stable while its request is high.
module cmesh_out_port #(
    parameter int N = 8,
    parameter int W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   req,
    input  logic [N*W-1:0] in_data,
    output logic [N-1:0]   accept,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [W-1:0]   out_data
);
    logic [N-1:0] grant;
    logic         load;
    logic [W-1:0] sel;

    cmesh_rr_arbiter #(.N(N)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .advance (load),
        .grant   (grant)
    );

    // The register takes a new packet when it is empty or draining this cycle
    assign load   = (!out_valid || out_ready) && (|req);
    assign accept = grant & {N{load}};

    // Select the granted requester's packet
    always_comb begin
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) sel = sel | in_data[i*W +: W];
        end
    end

    // Hold, load or drain the output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= sel;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/cmesh_xbar.sv
// Crossbar core: takes a per-input legality and target index from the parent
// router, builds requests per output, and drops illegal packets with a sticky error.
// Assumes tgt is only meaningful where legal is high.
module cmesh_xbar #(
    parameter int N  = 8,
    parameter int W  = 13,
    parameter int TW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    in_valid,
    output logic [N-1:0]    in_ready,
    input  logic [N*W-1:0]  in_data,
    input  logic [N-1:0]    legal,
    input  logic [N*TW-1:0] tgt,
    output logic [N-1:0]    out_valid,
    input  logic [N-1:0]    out_ready,
    output logic [N*W-1:0]  out_data,
    output logic            err
);
    logic [N-1:0] req_by_out [N];
    logic [N-1:0] acc_by_out [N];

    // Steer each legal valid input to the output it targets
    always_comb begin
        for (int o = 0; o < N; o++) begin
            for (int i = 0; i < N; i++) begin
                req_by_out[o][i] = in_valid[i] && legal[i] && (tgt[i*TW +: TW] == TW'(o));
            end
        end
    end

    for (genvar o = 0; o < N; o++) begin : g_out
        cmesh_out_port #(.N(N), .W(W)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req_by_out[o]),
            .in_data   (in_data),
            .accept    (acc_by_out[o]),
            .out_valid (out_valid[o]),
            .out_ready (out_ready[o]),
            .out_data  (out_data[o*W +: W])
        );
    end

    // Illegal inputs are always taken (dropped); legal ones when granted
    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic r;
            r = !legal[i];
            for (int o = 0; o < N; o++) r = r | acc_by_out[o][i];
            in_ready[i] = r;
        end
    end

    // Remember any dropped packet until reset
    always_ff @(posedge clk) begin
        if (!rst_n)                          err <= 1'b0;
        else if (|(in_valid & ~legal))       err <= 1'b1;
    end
endmodule

// File: rtl/cmesh_group_router.sv
// Group router: ports 0-3 local tiles, 4-6 peer groups, 7 central router.
// Tile inputs may go anywhere. Peer and central inputs may only target a local tile.
// Assumes peer slot k links to group (GROUP_ID+1+k) mod 4.
module cmesh_group_router
    import cmesh_pkg::*;
#(
    parameter int GROUP_ID = 0,
    parameter int DATA_W   = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [GRP_PORTS-1:0]            in_valid,
    output logic [GRP_PORTS-1:0]            in_ready,
    input  logic [GRP_PORTS*(ADDR_W+DATA_W)-1:0] in_data,
    output logic [GRP_PORTS-1:0]            out_valid,
    input  logic [GRP_PORTS-1:0]            out_ready,
    output logic [GRP_PORTS*(ADDR_W+DATA_W)-1:0] out_data,
    output logic                            err
);
    localparam int PKT_W = ADDR_W + DATA_W;
    localparam int TW    = $clog2(GRP_PORTS);

    logic [GRP_PORTS-1:0]    legal;
    logic [GRP_PORTS*TW-1:0] tgt;

    // Decode each input's destination into a legal flag and output index
    always_comb begin
        legal = '0;
        tgt   = '0;
        for (int i = 0; i < GRP_PORTS; i++) begin
            logic [ADDR_W-1:0] d;
            d = in_data[i*PKT_W + DATA_W +: ADDR_W];
            if (i < TILES_PER_GROUP) begin
                if (addr_is_host(d)) begin
                    legal[i]          = 1'b1;
                    tgt[i*TW +: TW]   = TW'(PORT_UP);
                end else if (addr_is_tile(d)) begin
                    legal[i] = 1'b1;
                    if (addr_group(d) == 2'(GROUP_ID))
                        tgt[i*TW +: TW] = TW'(addr_tile(d));
                    else
                        tgt[i*TW +: TW] = TW'(PORT_PEER0) + TW'(peer_slot(2'(GROUP_ID), addr_group(d)));
                end
            end else if (addr_is_tile(d) && addr_group(d) == 2'(GROUP_ID)) begin
                legal[i]        = 1'b1;
                tgt[i*TW +: TW] = TW'(addr_tile(d));
            end
        end
    end

    cmesh_xbar #(.N(GRP_PORTS), .W(PKT_W), .TW(TW)) u_xbar (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .legal     (legal),
        .tgt       (tgt),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .err       (err)
    );
endmodule

// File: rtl/cmesh_central_router.sv
// Central router: ports 0-3 face the group routers, port 4 faces the host.
// Group inputs may only target the host. The host may only target tiles.
module cmesh_central_router
    import cmesh_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [CTR_PORTS-1:0]                 in_valid,
    output logic [CTR_PORTS-1:0]                 in_ready,
    input  logic [CTR_PORTS*(ADDR_W+DATA_W)-1:0] in_data,
    output logic [CTR_PORTS-1:0]                 out_valid,
    input  logic [CTR_PORTS-1:0]                 out_ready,
    output logic [CTR_PORTS*(ADDR_W+DATA_W)-1:0] out_data,
    output logic                                 err
);
    localparam int PKT_W = ADDR_W + DATA_W;
    localparam int TW    = $clog2(CTR_PORTS);

    logic [CTR_PORTS-1:0]    legal;
    logic [CTR_PORTS*TW-1:0] tgt;

    // Upward traffic goes to the host; downward traffic to the addressed group
    always_comb begin
        legal = '0;
        tgt   = '0;
        for (int i = 0; i < CTR_PORTS; i++) begin
            logic [ADDR_W-1:0] d;
            d = in_data[i*PKT_W + DATA_W +: ADDR_W];
            if (i == PORT_HOST) begin
                legal[i]        = addr_is_tile(d);
                tgt[i*TW +: TW] = TW'(addr_group(d));
            end else begin
                legal[i]        = addr_is_host(d);
                tgt[i*TW +: TW] = TW'(PORT_HOST);
            end
        end
    end

    cmesh_xbar #(.N(CTR_PORTS), .W(PKT_W), .TW(TW)) u_xbar (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .legal     (legal),
        .tgt       (tgt),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .err       (err)
    );
endmodule

// File: rtl/cmesh_fabric.sv
// Fabric top: four group routers in a full peer mesh plus one central router.
// Tile k attaches to group k/4, local port k%4. The host attaches to the central router.
module cmesh_fabric
    import cmesh_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_TILES-1:0]                 tile_in_valid,
    output logic [NUM_TILES-1:0]                 tile_in_ready,
    input  logic [NUM_TILES*(ADDR_W+DATA_W)-1:0] tile_in_data,
    output logic [NUM_TILES-1:0]                 tile_out_valid,
    input  logic [NUM_TILES-1:0]                 tile_out_ready,
    output logic [NUM_TILES*(ADDR_W+DATA_W)-1:0] tile_out_data,
    input  logic                                 host_in_valid,
    output logic                                 host_in_ready,
    input  logic [ADDR_W+DATA_W-1:0]             host_in_data,
    output logic                                 host_out_valid,
    input  logic                                 host_out_ready,
    output logic [ADDR_W+DATA_W-1:0]             host_out_data,
    output logic                                 err_flag
);
    localparam int PKT_W = ADDR_W + DATA_W;

    logic [GRP_PORTS-1:0]       g_iv [NUM_GROUPS];
    logic [GRP_PORTS-1:0]       g_ir [NUM_GROUPS];
    logic [GRP_PORTS*PKT_W-1:0] g_id [NUM_GROUPS];
    logic [GRP_PORTS-1:0]       g_ov [NUM_GROUPS];
    logic [GRP_PORTS-1:0]       g_or [NUM_GROUPS];
    logic [GRP_PORTS*PKT_W-1:0] g_od [NUM_GROUPS];
    logic [NUM_GROUPS-1:0]      g_err;

    logic [CTR_PORTS-1:0]       c_iv, c_ir, c_ov, c_or;
    logic [CTR_PORTS*PKT_W-1:0] c_id, c_od;
    logic                       c_err;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        cmesh_group_router #(.GROUP_ID(g), .DATA_W(DATA_W)) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (g_iv[g]),
            .in_ready  (g_ir[g]),
            .in_data   (g_id[g]),
            .out_valid (g_ov[g]),
            .out_ready (g_or[g]),
            .out_data  (g_od[g]),
            .err       (g_err[g])
        );

        // Local tile attachments
        for (genvar t = 0; t < TILES_PER_GROUP; t++) begin : g_tile
            localparam int K = g*TILES_PER_GROUP + t;
            assign g_iv[g][t]                = tile_in_valid[K];
            assign g_id[g][t*PKT_W +: PKT_W] = tile_in_data[K*PKT_W +: PKT_W];
            assign tile_in_ready[K]          = g_ir[g][t];
            assign tile_out_valid[K]         = g_ov[g][t];
            assign tile_out_data[K*PKT_W +: PKT_W] = g_od[g][t*PKT_W +: PKT_W];
            assign g_or[g][t]                = tile_out_ready[K];
        end

        // Direct peer links: slot k of group g lands on slot (2-k) of group (g+1+k)%4
        for (genvar k = 0; k < PEER_CNT; k++) begin : g_peer
            localparam int H  = (g + 1 + k) % NUM_GROUPS;
            localparam int SO = PORT_PEER0 + k;
            localparam int SI = PORT_PEER0 + (PEER_CNT - 1 - k);
            assign g_iv[H][SI]                 = g_ov[g][SO];
            assign g_id[H][SI*PKT_W +: PKT_W]  = g_od[g][SO*PKT_W +: PKT_W];
            assign g_or[g][SO]                 = g_ir[H][SI];
        end

        // Link between group g and the central router
        assign c_iv[g]                        = g_ov[g][PORT_UP];
        assign c_id[g*PKT_W +: PKT_W]         = g_od[g][PORT_UP*PKT_W +: PKT_W];
        assign g_or[g][PORT_UP]               = c_ir[g];
        assign g_iv[g][PORT_UP]               = c_ov[g];
        assign g_id[g][PORT_UP*PKT_W +: PKT_W] = c_od[g*PKT_W +: PKT_W];
        assign c_or[g]                        = g_ir[g][PORT_UP];
    end

    // Host attachment on the central router
    assign c_iv[PORT_HOST]                 = host_in_valid;
    assign c_id[PORT_HOST*PKT_W +: PKT_W]  = host_in_data;
    assign host_in_ready                   = c_ir[PORT_HOST];
    assign host_out_valid                  = c_ov[PORT_HOST];
    assign host_out_data                   = c_od[PORT_HOST*PKT_W +: PKT_W];
    assign c_or[PORT_HOST]                 = host_out_ready;

    cmesh_central_router #(.DATA_W(DATA_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (c_iv),
        .in_ready  (c_ir),
        .in_data   (c_id),
        .out_valid (c_ov),
        .out_ready (c_or),
        .out_data  (c_od),
        .err       (c_err)
    );

    assign err_flag = (|g_err) | c_err;
endmodule

// File: rtl/cmesh_fabric_sva.sv
// Checker for cmesh_fabric: port-level protocol, routing and error-flag properties.
module cmesh_fabric_sva
    import cmesh_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic [NUM_TILES-1:0]                 tile_out_valid,
    input logic [NUM_TILES-1:0]                 tile_out_ready,
    input logic [NUM_TILES*(ADDR_W+DATA_W)-1:0] tile_out_data,
    input logic                                 host_out_valid,
    input logic                                 host_out_ready,
    input logic [ADDR_W+DATA_W-1:0]             host_out_data,
    input logic                                 err_flag
);
    localparam int PKT_W = ADDR_W + DATA_W;

    for (genvar k = 0; k < NUM_TILES; k++) begin : g_tile_chk
        assert_tile_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            tile_out_valid[k] && !tile_out_ready[k] |=>
            tile_out_valid[k] && $stable(tile_out_data[k*PKT_W +: PKT_W]));

        assert_tile_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
            tile_out_valid[k] |-> tile_out_data[k*PKT_W + DATA_W +: ADDR_W] == ADDR_W'(k));
    end

    assert_host_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_out_valid && !host_out_ready |=> host_out_valid && $stable(host_out_data));

    assert_host_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_out_valid |-> host_out_data[DATA_W +: ADDR_W] == HOST_ADDR);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tile_out_valid == '0) && !host_out_valid && !err_flag);
endmodule

bind cmesh_fabric cmesh_fabric_sva #(.DATA_W(DATA_W)) u_sva (.*);

// File: tb/cmesh_fabric_test.sv
module cmesh_fabric_test;
    localparam int DW = 16;
    localparam int PW = 5 + DW;
    localparam int NS = 17;   // 16 tiles + host at index 16

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [15:0]      t_iv, t_ir, t_ov, t_or;
    logic [16*PW-1:0] t_id, t_od;
    logic             h_iv, h_ir, h_ov, h_or;
    logic [PW-1:0]    h_id, h_od;
    logic             err;

    logic [NS-1:0] sv;
    logic [NS-1:0] ro;
    logic [PW-1:0] sp [NS];

    always_comb begin
        for (int k = 0; k < 16; k++) t_id[k*PW +: PW] = sp[k];
        t_iv = sv[15:0];
        t_or = ro[15:0];
        h_iv = sv[16];
        h_id = sp[16];
        h_or = ro[16];
    end

    cmesh_fabric #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .tile_in_valid(t_iv), .tile_in_ready(t_ir), .tile_in_data(t_id),
        .tile_out_valid(t_ov), .tile_out_ready(t_or), .tile_out_data(t_od),
        .host_in_valid(h_iv), .host_in_ready(h_ir), .host_in_data(h_id),
        .host_out_valid(h_ov), .host_out_ready(h_or), .host_out_data(h_od),
        .err_flag(err)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [4:0] exp_dest [1024];
    bit         outstanding [1024];
    int         next_id;

    function automatic logic in_rdy(input int k);
        return (k < 16) ? t_ir[k] : h_ir;
    endfunction
    function automatic logic out_v(input int k);
        return (k < 16) ? t_ov[k] : h_ov;
    endfunction
    function automatic logic [PW-1:0] out_d(input int k);
        return (k < 16) ? t_od[k*PW +: PW] : h_od;
    endfunction
    // Expected output index for a legal destination
    function automatic int dest_port(input logic [4:0] a);
        return (a == 5'h10) ? 16 : int'(a[3:0]);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sv = '0;
        ro = '1;
        for (int k = 0; k < NS; k++) sp[k] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // Send one packet and measure cycles until it appears at its destination
    task automatic lat_test(input int src, input logic [4:0] dest, input int exp_lat, input string tag);
        int lat;
        int dp;
        logic [15:0] id;
        id = 16'(next_id);
        next_id++;
        dp = dest_port(dest);
        sv[src] = 1'b1;
        sp[src] = {dest, id};
        @(negedge clk);
        chk(in_rdy(src) == 1'b1, {tag, " input ready"}, int'(in_rdy(src)), 1);
        @(posedge clk); #1;
        sv[src] = 1'b0;
        lat = -1;
        for (int n = 1; n <= 4; n++) begin
            @(negedge clk);
            if (lat < 0 && out_v(dp) && out_d(dp) == {dest, id}) lat = n;
        end
        @(posedge clk); #1;
        chk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        next_id = 0;
        for (int i = 0; i < 1024; i++) begin outstanding[i] = 0; exp_dest[i] = '0; end
        do_reset();

        // R1: quiet state out of reset
        @(negedge clk);
        chk(t_ov == '0 && !h_ov, "R1 valids after reset", int'({h_ov, t_ov}), 0);
        chk(!err, "R1 err after reset", int'(err), 0);
        @(posedge clk); #1;

        // R2: same-group delivery in one cycle
        lat_test(5, 5'h06, 1, "R2 tile5->tile6");
        lat_test(12, 5'h0F, 1, "R2 tile12->tile15");
        // R3: cross-group over the peer link in two cycles
        lat_test(0, 5'h0D, 2, "R3 tile0->tile13");
        lat_test(15, 5'h02, 2, "R3 tile15->tile2");
        lat_test(7, 5'h08, 2, "R3 tile7->tile8");
        // R4: tile to host
        lat_test(9, 5'h10, 2, "R4 tile9->host");
        // R5: host to tile
        lat_test(16, 5'h0B, 2, "R5 host->tile11");
        lat_test(16, 5'h00, 2, "R5 host->tile0");

        // R6: stalled output holds its packet stable
        begin
            logic [PW-1:0] want;
            int seen;
            want = {5'h03, 16'h0abc};
            ro[3] = 1'b0;
            sv[1] = 1'b1; sp[1] = want;
            @(posedge clk); #1; sv[1] = 1'b0;
            for (int n = 0; n < 4; n++) begin
                @(negedge clk);
                chk(t_ov[3] && t_od[3*PW +: PW] == want, "R6 stall hold",
                    int'(t_od[3*PW +: PW]), int'(want));
            end
            @(posedge clk); #1; ro[3] = 1'b1;
            seen = 0;
            for (int n = 0; n < 3; n++) begin
                @(negedge clk);
                if (t_ov[3]) seen++;
            end
            @(posedge clk); #1;
            chk(seen == 1, "R6 delivered once after release", seen, 1);
        end

        // R7: two tiles contending for tile 2 alternate
        begin
            int prev;
            prev = -1;
            sv[0] = 1'b1; sp[0] = {5'h02, 16'd0};
            sv[1] = 1'b1; sp[1] = {5'h02, 16'd1};
            for (int n = 0; n < 10; n++) begin
                @(negedge clk);
                if (t_ov[2]) begin
                    int s;
                    s = int'(t_od[2*PW +: 16]);
                    if (prev >= 0) chk(s != prev, "R7 alternation", s, 1 - prev);
                    prev = s;
                end
            end
            @(posedge clk); #1; sv = '0;
            repeat (3) @(posedge clk); #1;
        end

        // R8: illegal tile destination is dropped and flags an error
        do_reset();
        sv[6] = 1'b1; sp[6] = {5'h17, 16'h0055};
        @(negedge clk);
        chk(in_rdy(6), "R8 illegal accepted", int'(in_rdy(6)), 1);
        @(posedge clk); #1; sv[6] = 1'b0;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            chk(t_ov == '0 && !h_ov, "R8 nothing delivered", int'({h_ov, t_ov}), 0);
        end
        chk(err, "R8 err raised", int'(err), 1);
        @(posedge clk); #1;
        lat_test(2, 5'h01, 1, "R2 legal after error");
        @(negedge clk);
        chk(err, "R8 err sticky", int'(err), 1);
        @(posedge clk); #1;

        // R8: host addressing itself is illegal
        do_reset();
        @(negedge clk);
        chk(!err, "R1 err cleared by reset", int'(err), 0);
        @(posedge clk); #1;
        sv[16] = 1'b1; sp[16] = {5'h10, 16'h0077};
        @(negedge clk);
        chk(in_rdy(16), "R8 host illegal accepted", int'(in_rdy(16)), 1);
        @(posedge clk); #1; sv[16] = 1'b0;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            chk(t_ov == '0 && !h_ov, "R8 host drop nothing delivered", int'({h_ov, t_ov}), 0);
        end
        chk(err, "R8 host err raised", int'(err), 1);
        @(posedge clk); #1;

        // Random traffic with scoreboard (R6, R9)
        do_reset();
        next_id = 0;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            bit fired [NS];
            @(negedge clk);
            for (int k = 0; k < NS; k++) begin
                fired[k] = sv[k] && in_rdy(k);
                if (fired[k]) begin
                    outstanding[int'(sp[k][9:0])] = 1;
                    exp_dest[int'(sp[k][9:0])] = sp[k][PW-1 -: 5];
                end
            end
            for (int k = 0; k < NS; k++) begin
                if (out_v(k) && ro[k]) begin
                    int id;
                    logic [PW-1:0] d;
                    d = out_d(k);
                    id = int'(d[9:0]);
                    chk(outstanding[id] && dest_port(exp_dest[id]) == k,
                        "R9 random delivery port", k, dest_port(exp_dest[id]));
                    outstanding[id] = 0;
                end
            end
            @(posedge clk); #1;
            for (int k = 0; k < NS; k++) begin
                if (fired[k]) sv[k] = 1'b0;
                if (!sv[k] && next_id < 1000 && cyc < 3800 && ($urandom % 3) == 0) begin
                    logic [4:0] d;
                    if (k < 16 && ($urandom % 4) == 0) d = 5'h10;
                    else d = 5'($urandom % 16);
                    sv[k] = 1'b1;
                    sp[k] = {d, 16'(next_id)};
                    next_id++;
                end
                ro[k] = (cyc >= 3800) ? 1'b1 : (($urandom % 4) != 0);
            end
        end
        begin
            int left;
            left = 0;
            for (int i = 0; i < 1024; i++) if (outstanding[i]) left++;
            chk(left == 0 && sv == '0, "R6 no packet lost", left, 0);
            chk(!err, "R8 no error on legal traffic", int'(err), 0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule